// File: doc/BRIEF.md
# Audio Coprocessor I/O Register Decoder

This block sits on the 16-bit address bus of a small audio processor. It sorts every access into one of several targets: a page of sixteen I/O registers at 0x00F0 to 0x00FF, a 64-byte boot ROM that can overlay the top of memory, and the backing RAM that holds everything else. Read data is selected within the same cycle as the access. Writes produce one-cycle strobes toward the sound DSP, the three timers and the RAM. They also update a small set of registers held inside the block.

The I/O page has several register behaviours. Some registers read as zero. The timer counters clear when read. The DSP registers are reached indirectly, through an address register and a data window. The host link is split: the host loads four input bytes through a side interface, and the processor sees those bytes at the port addresses. The processor's own writes to the same addresses go to four separate output bytes that only the host sees. Every processor write also reaches RAM, including writes to I/O addresses.

Top module: `snd_bus_decode`

## Requirements
- R1: After reset the boot ROM overlay is enabled, all timer enables are 0, the host-visible output ports read 0, the input ports and scratch bytes read 0, the DSP address is 0 and the timer targets are 0.
- R2: Reads of 0x00F0, 0x00F1, 0x00FA, 0x00FB and 0x00FC return 0. A write to 0x00F0 changes no register and no output other than the RAM write.
- R3: On a write to 0x00F1, bit k (k = 0..2) becomes timer_en_o[k]. timer_start_o[k] is high in the write cycle only when that bit is 1 and the timer was disabled.
- R4: On a write to 0x00F1, bit 4 clears input ports 0 and 1 and bit 5 clears input ports 2 and 3. When a host write to a port falls in the same cycle as a clear of that port, the clear wins.
- R5: Bit 7 of a 0x00F1 write sets the overlay flag. While the flag is set, a read at 0xFFC0+k returns the ROM byte (k*37+27) mod 256. Otherwise the read returns ram_rdata_i.
- R6: 0x00F2 is a readable and writable DSP address. dsp_addr_o carries its low 7 bits, and a read of 0x00F3 returns dsp_rdata_i.
- R7: A write to 0x00F3 raises dsp_wr_o with dsp_wdata_o equal to the write data, but only when bit 7 of the stored DSP address is 0.
- R8: Reads of 0x00F4+n (n = 0..3) return input port n, which the host loads with host_wr_i and host_sel_i = n. Processor writes to 0x00F4+n load host_port_o[8n+7:8n] and do not change what the processor reads back.
- R9: 0x00F8 and 0x00F9 are scratch bytes that read back what was last written.
- R10: A write to 0x00FA+k loads timer_tgt_o[8k+7:8k].
- R11: A read of 0x00FD+k returns {4'b0, timer_cnt_i[4k+3:4k]} and pulses timer_clr_o[k] in the same cycle.
- R12: Every processor write drives ram_wr_o with ram_addr_o and ram_wdata_o equal to the bus values. Reads outside the I/O page, and outside the overlay while it is enabled, return ram_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | Processor address |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read data, valid in the access cycle |
| host_wr_i | input | 1 | Host write to an input port |
| host_sel_i | input | 2 | Input port selected by the host |
| host_wdata_i | input | 8 | Host write data |
| host_port_o | output | 32 | Four output ports toward the host |
| dsp_addr_o | output | 7 | DSP register index |
| dsp_wr_o | output | 1 | DSP write strobe |
| dsp_wdata_o | output | 8 | DSP write data |
| dsp_rdata_i | input | 8 | DSP register read data |
| timer_en_o | output | 3 | Timer enables |
| timer_start_o | output | 3 | Timer restart pulses |
| timer_tgt_o | output | 24 | Timer target values |
| timer_cnt_i | input | 12 | Timer counter values |
| timer_clr_o | output | 3 | Counter clear on read |
| ram_addr_o | output | 16 | RAM address |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
A host write into an input port and a processor control write that clears that port can fall in the same clock cycle. The bench forces this case on purpose: in one negative half-cycle it drives the host strobe together with a 0x00F1 write that has the matching clear bit set, covering both port pairs. It then reads the port back and expects zero, while a port in the pair that is not cleared must keep the host value. Randomly interleaved host and processor operations hit the same case again against the bench's reference model.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  localparam int AW      = 16;
  localparam int DW      = 8;
  localparam int N_TMR   = 3;
  localparam int N_HPORT = 4;
  localparam int N_SCR   = 2;
  localparam int CNT_W   = 4;
  localparam int ROM_AW  = 6;
  localparam int HSEL_W  = $clog2(N_HPORT);

  localparam logic [AW-5:0] IO_PAGE  = 12'h00F;
  localparam logic [AW-1:0] ROM_BASE = 16'hFFC0;

  localparam int CTRL_CLR_LO = 4;
  localparam int CTRL_ROM    = 7;

  typedef enum logic [3:0] {
    RG_RAM, RG_TEST, RG_CTRL, RG_DADR, RG_DDAT,
    RG_PORT, RG_SCR, RG_TGT, RG_CNT, RG_ROM
  } region_e;

  typedef struct packed {
    region_e    rg;
    logic [2:0] idx;
  } dec_t;

  function automatic logic [DW-1:0] boot_byte(input logic [ROM_AW-1:0] k);
    logic [DW-1:0] t;
    t = DW'(k) * 8'd37;
    return t + 8'd27;
  endfunction
endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_dec_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic          rom_en_i,
  output dec_t          dec_o
);
  logic [3:0] lo;
  logic [3:0] off;

  assign lo = addr_i[3:0];

  always_comb begin
    dec_o = '{rg: RG_RAM, idx: 3'd0};
    off   = 4'd0;
    if (addr_i[AW-1:4] == IO_PAGE) begin
      unique case (lo)
        4'h0: dec_o.rg = RG_TEST;
        4'h1: dec_o.rg = RG_CTRL;
        4'h2: dec_o.rg = RG_DADR;
        4'h3: dec_o.rg = RG_DDAT;
        4'h4, 4'h5, 4'h6, 4'h7: begin
          dec_o.rg = RG_PORT;
          off      = lo - 4'h4;
        end
        4'h8, 4'h9: begin
          dec_o.rg = RG_SCR;
          off      = lo - 4'h8;
        end
        4'hA, 4'hB, 4'hC: begin
          dec_o.rg = RG_TGT;
          off      = lo - 4'hA;
        end
        default: begin
          dec_o.rg = RG_CNT;
          off      = lo - 4'hD;
        end
      endcase
      dec_o.idx = off[2:0];
    end else if (rom_en_i && addr_i >= ROM_BASE) begin
      dec_o.rg = RG_ROM;
    end
  end
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file
  import snd_dec_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  dec_t                          dec_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic                          host_wr_i,
  input  logic [HSEL_W-1:0]             host_sel_i,
  input  logic [DW-1:0]                 host_wdata_i,
  output logic                          rom_en_o,
  output logic [DW-1:0]                 dadr_o,
  output logic [N_HPORT-1:0][DW-1:0]    in_o,
  output logic [N_SCR-1:0][DW-1:0]      scr_o,
  output logic [N_HPORT-1:0][DW-1:0]    out_o,
  output logic [N_TMR-1:0]              tmr_en_o,
  output logic [N_TMR-1:0]              tmr_start_o,
  output logic [N_TMR-1:0][DW-1:0]      tgt_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (dec_i.rg == RG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_en_o <= 1'b1;
      dadr_o   <= '0;
    end else begin
      if (ctrl_wr)                        rom_en_o <= wdata_i[CTRL_ROM];
      if (wr_i && dec_i.rg == RG_DADR)    dadr_o   <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_HPORT; g++) begin : g_port
    logic clr, hwr, cwr;
    assign clr = ctrl_wr && wdata_i[CTRL_CLR_LO + g/2];
    assign hwr = host_wr_i && (host_sel_i == HSEL_W'(g));
    assign cwr = wr_i && dec_i.rg == RG_PORT && dec_i.idx == 3'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_o[g]  <= '0;
        out_o[g] <= '0;
      end else begin
        if (clr)      in_o[g] <= '0;   // clear has priority over host
        else if (hwr) in_o[g] <= host_wdata_i;
        if (cwr)      out_o[g] <= wdata_i;
      end
    end
  end

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scr_o[g] <= '0;
      else if (wr_i && dec_i.rg == RG_SCR && dec_i.idx == 3'(g)) scr_o[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign tmr_start_o[g] = ctrl_wr && wdata_i[g] && !tmr_en_o[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tmr_en_o[g] <= 1'b0;
        tgt_o[g]    <= '0;
      end else begin
        if (ctrl_wr) tmr_en_o[g] <= wdata_i[g];
        if (wr_i && dec_i.rg == RG_TGT && dec_i.idx == 3'(g)) tgt_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/snd_boot_rom.sv
module snd_boot_rom
  import snd_dec_pkg::*;
(
  input  logic [ROM_AW-1:0] addr_i,
  output logic [DW-1:0]     data_o
);
  localparam int DEPTH = 1 << ROM_AW;
  logic [DEPTH-1:0][DW-1:0] tbl;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    assign tbl[k] = boot_byte(ROM_AW'(k));
  end

  assign data_o = tbl[addr_i];
endmodule

// File: rtl/snd_bus_decode.sv
module snd_bus_decode
  import snd_dec_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           cpu_addr_i,
  input  logic                    cpu_rd_i,
  input  logic                    cpu_wr_i,
  input  logic [DW-1:0]           cpu_wdata_i,
  output logic [DW-1:0]           cpu_rdata_o,
  input  logic                    host_wr_i,
  input  logic [HSEL_W-1:0]       host_sel_i,
  input  logic [DW-1:0]           host_wdata_i,
  output logic [N_HPORT*DW-1:0]   host_port_o,
  output logic [DW-2:0]           dsp_addr_o,
  output logic                    dsp_wr_o,
  output logic [DW-1:0]           dsp_wdata_o,
  input  logic [DW-1:0]           dsp_rdata_i,
  output logic [N_TMR-1:0]        timer_en_o,
  output logic [N_TMR-1:0]        timer_start_o,
  output logic [N_TMR*DW-1:0]     timer_tgt_o,
  input  logic [N_TMR*CNT_W-1:0]  timer_cnt_i,
  output logic [N_TMR-1:0]        timer_clr_o,
  output logic [AW-1:0]           ram_addr_o,
  output logic                    ram_wr_o,
  output logic [DW-1:0]           ram_wdata_o,
  input  logic [DW-1:0]           ram_rdata_i
);
  dec_t                        dec;
  logic                        rom_en;
  logic [DW-1:0]               dadr;
  logic [N_HPORT-1:0][DW-1:0]  in_q;
  logic [N_SCR-1:0][DW-1:0]    scr_q;
  logic [N_HPORT-1:0][DW-1:0]  out_q;
  logic [N_TMR-1:0][DW-1:0]    tgt_q;
  logic [DW-1:0]               rom_data;

  snd_addr_decode u_dec (
    .addr_i   (cpu_addr_i),
    .rom_en_i (rom_en),
    .dec_o    (dec)
  );

  snd_reg_file u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cpu_wr_i),
    .dec_i        (dec),
    .wdata_i      (cpu_wdata_i),
    .host_wr_i    (host_wr_i),
    .host_sel_i   (host_sel_i),
    .host_wdata_i (host_wdata_i),
    .rom_en_o     (rom_en),
    .dadr_o       (dadr),
    .in_o         (in_q),
    .scr_o        (scr_q),
    .out_o        (out_q),
    .tmr_en_o     (timer_en_o),
    .tmr_start_o  (timer_start_o),
    .tgt_o        (tgt_q)
  );

  snd_boot_rom u_rom (
    .addr_i (cpu_addr_i[ROM_AW-1:0]),
    .data_o (rom_data)
  );

  assign host_port_o = out_q;
  assign timer_tgt_o = tgt_q;

  assign dsp_addr_o  = dadr[DW-2:0];
  assign dsp_wdata_o = cpu_wdata_i;
  assign dsp_wr_o    = cpu_wr_i && (dec.rg == RG_DDAT) && !dadr[DW-1];

  assign ram_addr_o  = cpu_addr_i;
  assign ram_wdata_o = cpu_wdata_i;
  assign ram_wr_o    = cpu_wr_i;

  for (genvar g = 0; g < N_TMR; g++) begin : g_clr
    assign timer_clr_o[g] = cpu_rd_i && (dec.rg == RG_CNT) && (dec.idx == 3'(g));
  end

  always_comb begin
    unique case (dec.rg)
      RG_TEST, RG_CTRL, RG_TGT: cpu_rdata_o = '0;
      RG_DADR: cpu_rdata_o = dadr;
      RG_DDAT: cpu_rdata_o = dsp_rdata_i;
      RG_PORT: cpu_rdata_o = in_q[dec.idx[HSEL_W-1:0]];
      RG_SCR:  cpu_rdata_o = scr_q[dec.idx[0]];
      RG_CNT:  cpu_rdata_o = DW'(timer_cnt_i[dec.idx[1:0]*CNT_W +: CNT_W]);
      RG_ROM:  cpu_rdata_o = rom_data;
      default: cpu_rdata_o = ram_rdata_i;
    endcase
  end
endmodule

// File: rtl/snd_bus_decode_chk.sv
module snd_bus_decode_chk
  import snd_dec_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AW-1:0]        cpu_addr_i,
  input logic                 cpu_rd_i,
  input logic                 cpu_wr_i,
  input logic [DW-1:0]        cpu_wdata_i,
  input logic [DW-2:0]        dsp_addr_o,
  input logic                 dsp_wr_o,
  input logic [DW-1:0]        dsp_wdata_o,
  input logic [N_TMR-1:0]     timer_en_o,
  input logic [N_TMR-1:0]     timer_start_o,
  input logic [N_TMR-1:0]     timer_clr_o,
  input logic [AW-1:0]        ram_addr_o,
  input logic                 ram_wr_o,
  input logic [DW-1:0]        ram_wdata_o
);
  a_r12_ram_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i |-> ram_wr_o && ram_addr_o == cpu_addr_i && ram_wdata_o == cpu_wdata_i);

  a_r7_dsp_wr_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_wr_o |-> cpu_wr_i && cpu_addr_i == 16'h00F3 && dsp_wdata_o == cpu_wdata_i);

  a_r3_start_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_start_o & timer_en_o) == '0);

  a_r3_start_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start_o != '0 |=> (timer_en_o & $past(timer_start_o)) == $past(timer_start_o));

  a_r11_clr_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr_o != '0 |-> cpu_rd_i && $onehot0(timer_clr_o));

  a_r6_dadr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_wr_i && cpu_addr_i == 16'h00F2) |=> $stable(dsp_addr_o));
endmodule

bind snd_bus_decode snd_bus_decode_chk u_chk (.*);

// File: tb/snd_bus_decode_tb_top.sv
module snd_bus_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] host_port;
  logic [6:0]  dsp_addr;
  logic        dsp_wr;
  logic [7:0]  dsp_wdata, dsp_rdata = '0;
  logic [2:0]  t_en, t_start, t_clr;
  logic [23:0] t_tgt;
  logic [11:0] t_cnt = '0;
  logic [15:0] ram_addr;
  logic        ram_wr;
  logic [7:0]  ram_wdata, ram_rdata = '0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  snd_bus_decode dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .host_wr_i(host_wr), .host_sel_i(host_sel), .host_wdata_i(host_wdata),
    .host_port_o(host_port),
    .dsp_addr_o(dsp_addr), .dsp_wr_o(dsp_wr), .dsp_wdata_o(dsp_wdata),
    .dsp_rdata_i(dsp_rdata),
    .timer_en_o(t_en), .timer_start_o(t_start), .timer_tgt_o(t_tgt),
    .timer_cnt_i(t_cnt), .timer_clr_o(t_clr),
    .ram_addr_o(ram_addr), .ram_wr_o(ram_wr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  // reference model
  logic [7:0] m_in [6];
  logic [7:0] m_out [4];
  logic [7:0] m_tgt [3];
  logic [7:0] m_dadr;
  logic [2:0] m_en;
  logic       m_rom;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_byte(input logic [5:0] k);
    logic [7:0] t;
    t = {2'b00, k} * 8'd37;
    return t + 8'd27;
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (a[15:4] == 12'h00F) begin
      case (a[3:0])
        4'h2: return m_dadr;
        4'h3: return dsp_rdata;
        4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9: return m_in[a[3:0] - 4'h4];
        4'hD: return {4'b0, t_cnt[3:0]};
        4'hE: return {4'b0, t_cnt[7:4]};
        4'hF: return {4'b0, t_cnt[11:8]};
        default: return 8'h00;
      endcase
    end
    if (m_rom && a >= 16'hFFC0) return rom_byte(a[5:0]);
    return ram_rdata;
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (a[15:4] != 12'h00F) return (a >= 16'hFFC0) ? "R5" : "R12";
    case (a[3:0])
      4'h0, 4'h1, 4'hA, 4'hB, 4'hC: return "R2";
      4'h2, 4'h3: return "R6";
      4'h4, 4'h5, 4'h6, 4'h7: return "R8";
      4'h8, 4'h9: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] m_port_vec();
    return {m_out[3], m_out[2], m_out[1], m_out[0]};
  endfunction

  function automatic logic [23:0] m_tgt_vec();
    return {m_tgt[2], m_tgt[1], m_tgt[0]};
  endfunction

  task automatic model_host(input logic [1:0] s, input logic [7:0] d);
    m_in[s] = d;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a[15:4] != 12'h00F) return;
    case (a[3:0])
      4'h1: begin
        m_en = d[2:0];
        if (d[4]) begin m_in[0] = 0; m_in[1] = 0; end
        if (d[5]) begin m_in[2] = 0; m_in[3] = 0; end
        m_rom = d[7];
      end
      4'h2: m_dadr = d;
      4'h4, 4'h5, 4'h6, 4'h7: m_out[a[1:0]] = d;
      4'h8, 4'h9: m_in[a[3:0] - 4'h4] = d;
      4'hA, 4'hB, 4'hC: m_tgt[a[3:0] - 4'hA] = d;
      default: ;
    endcase
  endtask

  // optional same-cycle host write
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                           input bit with_host = 0, input logic [1:0] hs = 0,
                           input logic [7:0] hd = 0);
    logic [2:0] exp_start;
    logic       exp_dwr;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    host_wr = with_host; host_sel = hs; host_wdata = hd;
    exp_start = (a == 16'h00F1) ? (d[2:0] & ~m_en) : 3'b000;
    exp_dwr   = (a == 16'h00F3) && !m_dadr[7];
    #1;
    chk("R3", t_start, exp_start);
    chk("R7", {dsp_wr, dsp_wdata}, {exp_dwr, exp_dwr ? d : dsp_wdata});
    chk("R12", {ram_wr, ram_addr, ram_wdata}, {1'b1, a, d});
    @(posedge clk); #1;
    cpu_wr = 1'b0; host_wr = 1'b0;
    if (with_host) model_host(hs, hd);
    model_write(a, d);
    chk("R8", host_port, m_port_vec());
    chk("R10", t_tgt, m_tgt_vec());
    chk("R3", t_en, m_en);
  endtask

  task automatic host_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
    model_host(s, d);
  endtask

  task automatic cpu_read(input logic [15:0] a);
    logic [2:0] exp_clr;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    ram_rdata = 8'($urandom); dsp_rdata = 8'($urandom); t_cnt = 12'($urandom);
    exp_clr = 3'b000;
    if (a == 16'h00FD) exp_clr = 3'b001;
    if (a == 16'h00FE) exp_clr = 3'b010;
    if (a == 16'h00FF) exp_clr = 3'b100;
    #1;
    chk(req_of(a), cpu_rdata, exp_read(a));
    chk("R11", t_clr, exp_clr);
    if (a == 16'h00F3) chk("R6", dsp_addr, m_dadr[6:0]);
    cpu_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_A7C3));
    for (int i = 0; i < 6; i++) m_in[i] = 0;
    for (int i = 0; i < 4; i++) m_out[i] = 0;
    for (int i = 0; i < 3; i++) m_tgt[i] = 0;
    m_dadr = 0; m_en = 0; m_rom = 1;
    #9 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1", {t_en, host_port, t_tgt, dsp_addr}, '0);
    cpu_read(16'hFFC0);
    cpu_read(16'hFFFF);
    for (int a = 16'h00F4; a <= 16'h00F9; a++) cpu_read(16'(a));
    cpu_read(16'h00F2);

    // R2 zero reads and test register
    cpu_write(16'h00F0, 8'hFF);
    cpu_write(16'h00FA, 8'h5C);
    for (int a = 16'h00F0; a <= 16'h00F1; a++) cpu_read(16'(a));
    for (int a = 16'h00FA; a <= 16'h00FC; a++) cpu_read(16'(a));

    // R3 timer enables and start pulses
    cpu_write(16'h00F1, 8'h85);
    cpu_write(16'h00F1, 8'h87);
    cpu_write(16'h00F1, 8'h82);

    // R5 overlay off then on
    cpu_write(16'h00F1, 8'h00);
    cpu_read(16'hFFC5);
    cpu_write(16'h00F1, 8'h80);
    cpu_read(16'hFFC5);
    cpu_read(16'hFFBF);

    // R6/R7 indirect DSP access
    cpu_write(16'h00F2, 8'h7F);
    cpu_write(16'h00F3, 8'hA1);
    cpu_read(16'h00F3);
    cpu_write(16'h00F2, 8'h80);
    cpu_write(16'h00F3, 8'hA2);
    cpu_read(16'h00F3);
    cpu_read(16'h00F2);

    // R8 host ports vs output ports
    for (int p = 0; p < 4; p++) host_write(2'(p), 8'(8'h10 + p));
    cpu_write(16'h00F5, 8'hEE);
    for (int a = 16'h00F4; a <= 16'h00F7; a++) cpu_read(16'(a));

    // R4 clear wins over same-cycle host write
    cpu_write(16'h00F1, 8'h90, 1, 2'd0, 8'h77);
    cpu_read(16'h00F4);
    cpu_read(16'h00F5);
    cpu_read(16'h00F6);
    cpu_write(16'h00F1, 8'hA0, 1, 2'd3, 8'h66);
    cpu_read(16'h00F7);
    cpu_write(16'h00F1, 8'h90, 1, 2'd2, 8'h55);
    cpu_read(16'h00F6);

    // R9 scratch
    cpu_write(16'h00F8, 8'h3C);
    cpu_write(16'h00F9, 8'hC3);
    cpu_read(16'h00F8);
    cpu_read(16'h00F9);

    // R11 counters
    for (int a = 16'h00FD; a <= 16'h00FF; a++) cpu_read(16'(a));

    // random mix
    for (int it = 0; it < 800; it++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom % 4);
      a = ($urandom % 2 == 0) ? (16'h00F0 | 16'($urandom % 16))
        : (($urandom % 2 == 0) ? (16'hFFC0 | 16'($urandom % 64)) : 16'($urandom));
      case (op)
        0: cpu_write(a, 8'($urandom));
        1: host_write(2'($urandom), 8'($urandom));
        2: cpu_write(16'h00F1, 8'($urandom), 1, 2'($urandom), 8'($urandom));
        default: cpu_read(a);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule